// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block takes an SDR SDRAM from power-up to a usable state and then keeps its contents alive. After reset it drives NOP on the command pins for a power-up wait. It then issues a PRECHARGE to all banks, a parameter-chosen number of AUTO REFRESH commands, and a LOAD MODE REGISTER that carries the CAS latency. After the mode-register settling time it raises an init-done flag.

From then on a free-running interval timer asks for a refresh at a fixed rate. The data-path controller answers the request with a grant when the memory is idle. The sequencer then issues the AUTO REFRESH and keeps the request high for the whole refresh recovery time, which tells the controller that the bus is still taken.

All timings are given as picosecond spans and converted to whole clock counts at elaboration, always rounding up. The gap between any two commands is counted in clocks.

Top module: `sdram_init_refresh`

## Requirements
- R1: While reset is held, the command pins show NOP (cs_n,ras_n,cas_n,we_n = 0111), the address is zero, and init_done and ref_req are low.
- R2: Every picosecond timing parameter becomes the smallest whole number of clock periods whose total duration is at least that span.
- R3: Number the first rising edge with reset released as edge 1. The PRECHARGE-all command (0010, address bit 10 high, all other address bits zero) is driven from edge P, where P is the rounded power-up delay. Before it, every edge gives NOP.
- R4: The first AUTO REFRESH (0001) comes the rounded precharge time after PRECHARGE. The further initial refreshes follow at spacings of the rounded refresh recovery time. There are exactly INIT_REFRESHES of them, and ref_grant has no effect during initialization.
- R5: LOAD MODE REGISTER (0000) comes one rounded refresh recovery time after the last initial refresh. Address bits [6:4] hold the CAS latency and all other address bits are zero, which selects burst length one and sequential order.
- R6: init_done rises exactly TMRD_CYC clocks after LOAD MODE REGISTER and never falls again. Every cycle without a listed command shows NOP.
- R7: ref_req first rises REFI clocks after init_done and is raised again every REFI clocks after that, where REFI is the rounded refresh interval.
- R8: AUTO REFRESH is issued on the first edge at which the sequencer is idle, a refresh is pending and ref_grant is high. ref_req then stays high for the rounded refresh recovery time after that command, and only then drops, unless a new interval has expired.
- R9: If the interval expires again while a request is still waiting, only one refresh stays owed. A single granted AUTO REFRESH clears the request.
- R10: ref_grant with no refresh owed issues nothing: the command pins stay at NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_grant | input | 1 | Data controller allows a refresh now |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_addr | output | ADDR_W | Address pins: bit 10 on precharge, mode word on load-mode |
| init_done | output | 1 | Power-up sequence finished |
| ref_req | output | 1 | Refresh owed or in progress |

## Verification
The bench builds two copies with a 20 ns clock. The first copy uses spans that are not whole multiples of the clock (170 ns power-up, 45 ns precharge, 70 ns refresh recovery, 610 ns interval), three initial refreshes and CAS latency 2, so every conversion must round up. The second copy uses exact multiples, one initial refresh, CAS latency 3 and a three-clock mode settle, so any over-rounding or off-by-one in a gap shows up. The short power-up and refresh intervals put the whole boot sequence and eight refresh intervals within a few hundred cycles, and every cycle is compared against arithmetic expectations. The grant is held high through initialization and is then withheld across two interval expiries, which exercises the ignored grant, the single owed refresh and the bus hold after a refresh.

// File: rtl/sdr_seq_pkg.sv
`timescale 1ns/1ps
// Shared command encodings, operation and state types, and elaboration-time
// helpers for the SDRAM power-up and refresh sequencer.
// Assumes all timing spans fit in 32-bit picosecond values.
package sdr_seq_pkg;

    // Command pin patterns, ordered {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP       = 4'b0111;
    localparam logic [3:0] CMD_PRECHARGE = 4'b0010;
    localparam logic [3:0] CMD_REFRESH   = 4'b0001;
    localparam logic [3:0] CMD_LOAD_MODE = 4'b0000;

    // Operation requested by the sequencer for the command driver
    typedef enum logic [1:0] {
        OP_PRECHARGE = 2'd0,
        OP_REFRESH   = 2'd1,
        OP_LOAD_MODE = 2'd2
    } sdr_op_e;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_POWERUP       = 3'd0,
        ST_PRE_WAIT      = 3'd1,
        ST_BOOT_REF_WAIT = 3'd2,
        ST_MODE_WAIT     = 3'd3,
        ST_IDLE          = 3'd4,
        ST_REF_WAIT      = 3'd5
    } seq_state_e;

    // Smallest clock count whose duration covers the requested span
    function automatic int unsigned cycles_ceil(input int unsigned span_ps,
                                                input int unsigned period_ps);
        longint unsigned num;
        num = longint'(span_ps) + longint'(period_ps) - 64'd1;
        return int'(num / longint'(period_ps));
    endfunction

    // Bits needed to hold values 0..v, at least one
    function automatic int unsigned bits_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

    // Larger of two counts
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdr_gap_timer.sv
`timescale 1ns/1ps
// Inter-command gap counter. Loaded with (gap - 1) on the edge that issues a
// command; reports expiry once it has counted down to zero, so the next
// command can go out exactly `gap` edges after the previous one.
// Assumes RESET_LOAD fits in W bits; it sets the power-up wait.
module sdr_gap_timer #(
    parameter int unsigned W          = 8,
    parameter int unsigned RESET_LOAD = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] count_q;

    // Count down to zero, reload on request, start with the power-up wait
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= W'(RESET_LOAD);
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    // Expiry flag for the sequencer
    always_comb begin
        expired = (count_q == '0);
    end

endmodule

// File: rtl/sdr_refresh_timer.sv
`timescale 1ns/1ps
// Periodic refresh interval timer. Held at its start value until enabled,
// then produces a one-cycle tick every PERIOD clocks, the first one PERIOD
// clocks after enable rises.
// Assumes PERIOD >= 1 and fits in W bits.
module sdr_refresh_timer #(
    parameter int unsigned W      = 10,
    parameter int unsigned PERIOD = 782
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tick
);

    localparam logic [W-1:0] START = W'(PERIOD - 1);

    logic [W-1:0] count_q;

    // Free-running down-counter with automatic reload
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            count_q <= START;
        end else if (count_q == '0) begin
            count_q <= START;
        end else begin
            count_q <= count_q - 1'b1;
        end
    end

    // Interval expiry strobe
    always_comb begin
        tick = enable && (count_q == '0);
    end

endmodule

// File: rtl/sdr_cmd_drive.sv
`timescale 1ns/1ps
// Registered command and address driver. Turns a one-cycle issue strobe and
// operation code into the pin pattern and the matching address word; drives
// NOP and a zero address otherwise.
// Assumes ADDR_W >= 11 so that the all-banks bit 10 exists.
module sdr_cmd_drive
    import sdr_seq_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned CAS_LATENCY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  sdr_op_e           op,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr
);

    localparam int unsigned   CAS_LSB   = 4;
    localparam int unsigned   ALL_BANKS = 10;
    localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(CAS_LATENCY) << CAS_LSB;
    localparam logic [ADDR_W-1:0] PRE_WORD  = ADDR_W'(1) << ALL_BANKS;

    logic [3:0]        pins_d, pins_q;
    logic [ADDR_W-1:0] addr_d, addr_q;

    // Choose pin pattern and address for the requested operation
    always_comb begin
        pins_d = CMD_NOP;
        addr_d = '0;
        if (issue) begin
            case (op)
                OP_PRECHARGE: begin
                    pins_d = CMD_PRECHARGE;
                    addr_d = PRE_WORD;
                end
                OP_REFRESH: begin
                    pins_d = CMD_REFRESH;
                end
                OP_LOAD_MODE: begin
                    pins_d = CMD_LOAD_MODE;
                    addr_d = MODE_WORD;
                end
                default: begin
                    pins_d = CMD_NOP;
                end
            endcase
        end
    end

    // Output registers, NOP in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= CMD_NOP;
            addr_q <= '0;
        end else begin
            pins_q <= pins_d;
            addr_q <= addr_d;
        end
    end

    // Split the pin pattern onto the ports
    always_comb begin
        {cs_n, ras_n, cas_n, we_n} = pins_q;
        addr = addr_q;
    end

endmodule

// File: rtl/sdr_init_fsm.sv
`timescale 1ns/1ps
// Sequencer state machine. Walks the power-up order (wait, precharge-all,
// N auto-refreshes, load mode, settle) and then serves periodic refreshes
// through a request/grant handshake. A single pending flag records an owed
// refresh; further interval ticks while it is set add nothing.
// Assumes every gap is at least one clock and INIT_REFRESHES is 1..8.
module sdr_init_fsm
    import sdr_seq_pkg::*;
#(
    parameter int unsigned GAP_W          = 8,
    parameter int unsigned TRP_CYC        = 1,
    parameter int unsigned TRFC_CYC       = 4,
    parameter int unsigned TMRD_CYC       = 2,
    parameter int unsigned INIT_REFRESHES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gap_expired,
    input  logic             interval_tick,
    input  logic             ref_grant,
    output logic             issue,
    output sdr_op_e          op,
    output logic             gap_load,
    output logic [GAP_W-1:0] gap_val,
    output logic             init_done,
    output logic             ref_req
);

    localparam int unsigned      CNT_W    = bits_for(INIT_REFRESHES);
    localparam logic [CNT_W-1:0] BOOT_N   = CNT_W'(INIT_REFRESHES);
    localparam logic [GAP_W-1:0] TRP_LD   = GAP_W'(TRP_CYC - 1);
    localparam logic [GAP_W-1:0] TRFC_LD  = GAP_W'(TRFC_CYC - 1);
    localparam logic [GAP_W-1:0] TMRD_LD  = GAP_W'(TMRD_CYC - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] boot_refs_q, boot_refs_d;
    logic             done_q, done_d;
    logic             pending_q, pending_d;
    logic             serve;

    // Next-state, command request and gap reload decisions
    always_comb begin
        state_d     = state_q;
        boot_refs_d = boot_refs_q;
        done_d      = done_q;
        issue       = 1'b0;
        op          = OP_REFRESH;
        gap_load    = 1'b0;
        gap_val     = '0;
        serve       = 1'b0;
        case (state_q)
            ST_POWERUP: begin
                if (gap_expired) begin
                    issue    = 1'b1;
                    op       = OP_PRECHARGE;
                    gap_load = 1'b1;
                    gap_val  = TRP_LD;
                    state_d  = ST_PRE_WAIT;
                end
            end
            ST_PRE_WAIT: begin
                if (gap_expired) begin
                    issue       = 1'b1;
                    op          = OP_REFRESH;
                    gap_load    = 1'b1;
                    gap_val     = TRFC_LD;
                    boot_refs_d = CNT_W'(1);
                    state_d     = ST_BOOT_REF_WAIT;
                end
            end
            ST_BOOT_REF_WAIT: begin
                if (gap_expired) begin
                    issue    = 1'b1;
                    gap_load = 1'b1;
                    if (boot_refs_q == BOOT_N) begin
                        op      = OP_LOAD_MODE;
                        gap_val = TMRD_LD;
                        state_d = ST_MODE_WAIT;
                    end else begin
                        op          = OP_REFRESH;
                        gap_val     = TRFC_LD;
                        boot_refs_d = boot_refs_q + 1'b1;
                    end
                end
            end
            ST_MODE_WAIT: begin
                if (gap_expired) begin
                    done_d  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (pending_q && ref_grant) begin
                    issue    = 1'b1;
                    op       = OP_REFRESH;
                    gap_load = 1'b1;
                    gap_val  = TRFC_LD;
                    serve    = 1'b1;
                    state_d  = ST_REF_WAIT;
                end
            end
            ST_REF_WAIT: begin
                if (gap_expired) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_POWERUP;
            end
        endcase
    end

    // Owed-refresh flag: a tick sets it (wins over service), service clears it
    always_comb begin
        if (interval_tick) begin
            pending_d = 1'b1;
        end else if (serve) begin
            pending_d = 1'b0;
        end else begin
            pending_d = pending_q;
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_POWERUP;
            boot_refs_q <= '0;
            done_q      <= 1'b0;
            pending_q   <= 1'b0;
        end else begin
            state_q     <= state_d;
            boot_refs_q <= boot_refs_d;
            done_q      <= done_d;
            pending_q   <= pending_d;
        end
    end

    // Handshake and status outputs
    always_comb begin
        init_done = done_q;
        ref_req   = pending_q || (state_q == ST_REF_WAIT);
    end

endmodule

// File: rtl/sdram_init_refresh.sv
`timescale 1ns/1ps
// SDRAM power-up and refresh sequencer, top level. Converts the picosecond
// timing parameters to clock counts (rounded up), and wires the gap timer,
// the refresh interval timer, the sequencer and the command driver.
// Assumes ADDR_W >= 11, INIT_REFRESHES in 1..8, CAS_LATENCY in 1..3,
// TMRD_CYC >= 1, and every span at least one clock.
module sdram_init_refresh
    import sdr_seq_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS  = 20000,
    parameter int unsigned POWERUP_PS     = 100000000,
    parameter int unsigned TRP_PS         = 20000,
    parameter int unsigned TRFC_PS        = 70000,
    parameter int unsigned TMRD_CYC       = 2,
    parameter int unsigned REFRESH_PS     = 15625000,
    parameter int unsigned INIT_REFRESHES = 2,
    parameter int unsigned CAS_LATENCY    = 3,
    parameter int unsigned ADDR_W         = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_grant,
    output logic              cmd_cs_n,
    output logic              cmd_ras_n,
    output logic              cmd_cas_n,
    output logic              cmd_we_n,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              init_done,
    output logic              ref_req
);

    localparam int unsigned PWR_CYC  = cycles_ceil(POWERUP_PS, CLK_PERIOD_PS);
    localparam int unsigned TRP_CYC  = cycles_ceil(TRP_PS, CLK_PERIOD_PS);
    localparam int unsigned TRFC_CYC = cycles_ceil(TRFC_PS, CLK_PERIOD_PS);
    localparam int unsigned REFI_CYC = cycles_ceil(REFRESH_PS, CLK_PERIOD_PS);
    localparam int unsigned GAP_MAX  = max2(max2(PWR_CYC, TRP_CYC), max2(TRFC_CYC, TMRD_CYC));
    localparam int unsigned GAP_W    = bits_for(GAP_MAX);
    localparam int unsigned REFI_W   = bits_for(REFI_CYC);

    logic             gap_expired;
    logic             gap_load;
    logic [GAP_W-1:0] gap_val;
    logic             interval_tick;
    logic             issue;
    sdr_op_e          op;
    logic             done_w;

    // Shared countdown for every inter-command gap, starting with power-up
    sdr_gap_timer #(
        .W          (GAP_W),
        .RESET_LOAD (PWR_CYC - 1)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .expired  (gap_expired)
    );

    // Periodic refresh interval, running once the boot sequence is over
    sdr_refresh_timer #(
        .W      (REFI_W),
        .PERIOD (REFI_CYC)
    ) u_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (done_w),
        .tick   (interval_tick)
    );

    // Boot and refresh sequencing
    sdr_init_fsm #(
        .GAP_W          (GAP_W),
        .TRP_CYC        (TRP_CYC),
        .TRFC_CYC       (TRFC_CYC),
        .TMRD_CYC       (TMRD_CYC),
        .INIT_REFRESHES (INIT_REFRESHES)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .gap_expired   (gap_expired),
        .interval_tick (interval_tick),
        .ref_grant     (ref_grant),
        .issue         (issue),
        .op            (op),
        .gap_load      (gap_load),
        .gap_val       (gap_val),
        .init_done     (done_w),
        .ref_req       (ref_req)
    );

    // Registered pins
    sdr_cmd_drive #(
        .ADDR_W      (ADDR_W),
        .CAS_LATENCY (CAS_LATENCY)
    ) u_drive (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (issue),
        .op    (op),
        .cs_n  (cmd_cs_n),
        .ras_n (cmd_ras_n),
        .cas_n (cmd_cas_n),
        .we_n  (cmd_we_n),
        .addr  (cmd_addr)
    );

    assign init_done = done_w;

endmodule

// File: rtl/sdr_seq_checks.sv
`timescale 1ns/1ps
// Protocol checker for the sequencer, attached by bind. Watches only the
// ports of the top module and keeps its own count of boot refreshes.
module sdr_seq_checks #(
    parameter int unsigned INIT_REFRESHES = 2,
    parameter int unsigned CAS_LATENCY    = 3,
    parameter int unsigned ADDR_W         = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_grant,
    input logic              cmd_cs_n,
    input logic              cmd_ras_n,
    input logic              cmd_cas_n,
    input logic              cmd_we_n,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              init_done,
    input logic              ref_req
);

    logic [3:0] pins;
    logic [3:0] boot_refs_q;

    always_comb begin
        pins = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
    end

    // Count refresh commands seen before init_done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_refs_q <= '0;
        end else if (!init_done && pins == 4'b0001) begin
            boot_refs_q <= boot_refs_q + 1'b1;
        end
    end

    assert_cmd_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pins inside {4'b0111, 4'b0010, 4'b0001, 4'b0000});

    assert_precharge_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0010) |-> (cmd_addr[10] && !init_done));

    assert_boot_ref_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (boot_refs_q == 4'(INIT_REFRESHES)));

    assert_mode_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0000) |-> ((cmd_addr[6:4] == 3'(CAS_LATENCY)) && !init_done));

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_req_after_boot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> init_done);

    assert_ref_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && pins == 4'b0001) |-> ($past(ref_grant) && $past(ref_req)));

endmodule

bind sdram_init_refresh sdr_seq_checks #(
    .INIT_REFRESHES (INIT_REFRESHES),
    .CAS_LATENCY    (CAS_LATENCY),
    .ADDR_W         (ADDR_W)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_grant (ref_grant),
    .cmd_cs_n  (cmd_cs_n),
    .cmd_ras_n (cmd_ras_n),
    .cmd_cas_n (cmd_cas_n),
    .cmd_we_n  (cmd_we_n),
    .cmd_addr  (cmd_addr),
    .init_done (init_done),
    .ref_req   (ref_req)
);

// File: tb/sdram_init_refresh_test.sv
`timescale 1ns/1ps
// Per-instance scoreboard: computes every expected cycle from the timing
// parameters, drives the grant pattern and compares at the falling edge.
module sdr_seq_scoreboard #(
    parameter int CLK_PS     = 20000,
    parameter int POWERUP_PS = 170000,
    parameter int TRP_PS     = 45000,
    parameter int TRFC_PS    = 70000,
    parameter int TMRD_CYC   = 2,
    parameter int REFRESH_PS = 610000,
    parameter int INIT_REFS  = 3,
    parameter int CAS        = 2,
    parameter int AW         = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic          done,
    input  logic          req,
    output logic          grant,
    output logic          finished
);

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    localparam int P        = cdiv(POWERUP_PS, CLK_PS);
    localparam int TRP      = cdiv(TRP_PS, CLK_PS);
    localparam int TRFC     = cdiv(TRFC_PS, CLK_PS);
    localparam int REFI     = cdiv(REFRESH_PS, CLK_PS);
    localparam int REF0_E   = P + TRP;
    localparam int LMR_E    = REF0_E + INIT_REFS * TRFC;
    localparam int DONE_E   = LMR_E + TMRD_CYC;
    localparam int HOLD_END = DONE_E + 2 * REFI + 8;
    localparam int LAST_E   = DONE_E + 8 * REFI;

    int n_chk = 0;
    int n_bad = 0;
    int edge_no = 0;
    int busy_end;
    bit pend = 1'b0;
    bit g_prev;

    initial begin
        grant    = 1'b1;
        g_prev   = 1'b1;
        finished = 1'b0;
        busy_end = DONE_E;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h (edge %0d)", tag, what, act, exp, edge_no);
        end
    endtask

    always @(posedge clk) edge_no <= rst_n ? edge_no + 1 : 0;

    always @(negedge clk) begin : scan
        logic [3:0]    pins;
        logic [3:0]    exp_pins;
        logic [AW-1:0] exp_addr;
        bit            ref_now;
        bit            exp_req;
        int            e;
        string         tag;
        pins = {cs_n, ras_n, cas_n, we_n};
        if (!rst_n) begin
            chk(pins == 4'b0111, "R1", "command in reset", int'(pins), 7);
            chk(!done && !req, "R1", "flags in reset", int'({done, req}), 0);
            chk(addr == '0, "R1", "address in reset", int'(addr), 0);
        end else if (edge_no <= LAST_E) begin
            e = edge_no;
            exp_req = 1'b0;
            ref_now = 1'b0;
            if (e == P) begin
                exp_pins = 4'b0010; tag = "R2 R3";
            end else if (e >= REF0_E && e < LMR_E && ((e - REF0_E) % TRFC) == 0) begin
                exp_pins = 4'b0001; tag = "R2 R4";
            end else if (e == LMR_E) begin
                exp_pins = 4'b0000; tag = "R5";
            end else if (e <= DONE_E) begin
                exp_pins = 4'b0111; tag = "R6";
            end else begin
                ref_now = (e > busy_end) && pend && g_prev;
                if (ref_now) busy_end = e + TRFC;
                if (((e - DONE_E) % REFI) == 0) pend = 1'b1;
                else if (ref_now) pend = 1'b0;
                exp_req = pend || (e < busy_end);
                exp_pins = ref_now ? 4'b0001 : 4'b0111;
                tag = (ref_now || !g_prev) ? "R8" : "R10";
            end
            if (exp_pins == 4'b0010) exp_addr = AW'(1) << 10;
            else if (exp_pins == 4'b0000) exp_addr = AW'(CAS) << 4;
            else exp_addr = '0;
            chk(pins == exp_pins, tag, "command", int'(pins), int'(exp_pins));
            chk(addr == exp_addr, (exp_pins == 4'b0000) ? "R5" : "R3", "address",
                int'(addr), int'(exp_addr));
            chk(done == (e >= DONE_E), "R6", "init_done", int'(done), int'(e >= DONE_E));
            chk(req == exp_req, (e > DONE_E + REFI) ? "R9" : "R7", "ref_req",
                int'(req), int'(exp_req));
            grant  = (e < DONE_E + 3) || (e >= HOLD_END);
            g_prev = grant;
        end else begin
            finished = 1'b1;
        end
    end

endmodule

// Top bench: two builds of the sequencer, each with its own scoreboard.
module sdram_init_refresh_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    always #10 clk = ~clk;

    logic        a_cs, a_ras, a_cas, a_we, a_done, a_req, a_grant, a_fin;
    logic [11:0] a_addr;
    logic        b_cs, b_ras, b_cas, b_we, b_done, b_req, b_grant, b_fin;
    logic [11:0] b_addr;

    sdram_init_refresh #(
        .CLK_PERIOD_PS (20000), .POWERUP_PS (170000), .TRP_PS (45000),
        .TRFC_PS (70000), .TMRD_CYC (2), .REFRESH_PS (610000),
        .INIT_REFRESHES (3), .CAS_LATENCY (2), .ADDR_W (12)
    ) uut (
        .clk (clk), .rst_n (rst_n), .ref_grant (a_grant),
        .cmd_cs_n (a_cs), .cmd_ras_n (a_ras), .cmd_cas_n (a_cas), .cmd_we_n (a_we),
        .cmd_addr (a_addr), .init_done (a_done), .ref_req (a_req)
    );

    sdr_seq_scoreboard #(
        .CLK_PS (20000), .POWERUP_PS (170000), .TRP_PS (45000), .TRFC_PS (70000),
        .TMRD_CYC (2), .REFRESH_PS (610000), .INIT_REFS (3), .CAS (2), .AW (12)
    ) sb_a (
        .clk (clk), .rst_n (rst_n), .cs_n (a_cs), .ras_n (a_ras), .cas_n (a_cas),
        .we_n (a_we), .addr (a_addr), .done (a_done), .req (a_req),
        .grant (a_grant), .finished (a_fin)
    );

    sdram_init_refresh #(
        .CLK_PERIOD_PS (20000), .POWERUP_PS (200000), .TRP_PS (40000),
        .TRFC_PS (60000), .TMRD_CYC (3), .REFRESH_PS (500000),
        .INIT_REFRESHES (1), .CAS_LATENCY (3), .ADDR_W (12)
    ) uut_edge (
        .clk (clk), .rst_n (rst_n), .ref_grant (b_grant),
        .cmd_cs_n (b_cs), .cmd_ras_n (b_ras), .cmd_cas_n (b_cas), .cmd_we_n (b_we),
        .cmd_addr (b_addr), .init_done (b_done), .ref_req (b_req)
    );

    sdr_seq_scoreboard #(
        .CLK_PS (20000), .POWERUP_PS (200000), .TRP_PS (40000), .TRFC_PS (60000),
        .TMRD_CYC (3), .REFRESH_PS (500000), .INIT_REFS (1), .CAS (3), .AW (12)
    ) sb_b (
        .clk (clk), .rst_n (rst_n), .cs_n (b_cs), .ras_n (b_ras), .cas_n (b_cas),
        .we_n (b_we), .addr (b_addr), .done (b_done), .req (b_req),
        .grant (b_grant), .finished (b_fin)
    );

    initial begin
        int cyc;
        int wd_bad;
        wd_bad = 0;
        repeat (5) @(negedge clk);
        #5 rst_n = 1'b1;
        cyc = 0;
        while (!(a_fin && b_fin) && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (cyc >= 5000) begin
            wd_bad = 1;
            $display("FAIL watchdog: run did not complete, got %0d cycles expected < 5000", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 sb_a.n_chk + sb_b.n_chk + wd_bad, sb_a.n_bad + sb_b.n_bad + wd_bad);
        $finish;
    end

endmodule